// File: doc/BRIEF.md
# Predicated vector rounding right shifter

This block takes a vector operand made of independent 64-bit unsigned lanes and shifts each lane right by an immediate amount, rounding half up. For a legal shift `s` an enabled lane becomes `(x + 2^(s-1)) >> s`. The sum is formed at 65 bits, so the carry out of the top bit is kept. A lane that the governing predicate leaves disabled passes through unchanged. The operation is destructive and merge-predicated: the operand is also the destination, and the result vector always holds every lane.

An operation is offered with a one-cycle strobe that carries the vector, the predicate and the shift. The whole result is registered and appears with a valid flag on the next cycle. A new operation can be offered every cycle. The predicate has one bit per vector byte, and only the lowest bit of each lane's eight-bit group is used. A shift outside 1..64 sets an error flag, and every lane is returned unchanged.

A small result state machine drives the flags. It has three states. RS_IDLE means there is no result this cycle. RS_OK means a valid result with a legal shift. RS_BAD means a valid result with a rejected shift. Every state moves each cycle on the strobe:
- no strobe goes to RS_IDLE;
- a strobe with a legal shift goes to RS_OK;
- a strobe with an illegal shift goes to RS_BAD.

The vector width `VLEN` may be 128, 256, 512, 1024 or 2048 bits.

Top module: `vrshr_unit`

## Requirements
- R1: After reset, `res_valid` is 0, `res_err` is 0 and `res_vec` is all zeros.
- R2: `res_valid` is 1 in exactly the cycle after each cycle with `op_valid` = 1, and 0 after each cycle with `op_valid` = 0; back-to-back strobes give back-to-back results.
- R3: For a legal shift `s` (1 ≤ s ≤ 64) on an enabled lane, the result lane equals `(x >> s) + x[s-1]`, which is `(x + 2^(s-1)) >> s` evaluated without losing the carry.
- R4: With `s` = 64, an enabled lane becomes bit 63 of its input (0 or 1).
- R5: An all-ones enabled lane gives `2^(64-s)` for s < 64 and 1 for s = 64.
- R6: Lane `i` (bits 64i+63..64i) is enabled when predicate bit `8i` is 1. A disabled lane keeps its input value. Predicate bits `8i+1`..`8i+7` have no effect.
- R7: A shift of 0 or 65..127 on `op_shamt` gives `res_err` = 1 and `res_vec` equal to `op_vec` in every lane, whatever the predicate.
- R8: A legal shift gives `res_err` = 0 along with the result.
- R9: In a cycle following no strobe, `res_vec` holds its previous value and `res_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | One-cycle strobe that offers an operation |
| op_vec | input | VLEN | Source and destination vector, 64-bit lanes |
| op_pred | input | VLEN/8 | Governing predicate, one bit per byte |
| op_shamt | input | 7 | Immediate shift amount, legal range 1..64 |
| res_valid | output | 1 | Result present this cycle |
| res_vec | output | VLEN | Registered result vector |
| res_err | output | 1 | Shift amount was rejected |

## Verification
The hardest case to reach is the carry out of bit 63 of the rounding sum. It only appears when the discarded half-weight bit and every bit above it are all ones. The lost-carry fault then shows only at large shifts or on near-all-ones lanes. The stimulus reaches it by giving every shift from 1 to 64 an all-ones vector, alongside random lanes. The reference uses the shift-plus-round-bit form, so a lost carry is not hidden by a model with the same flaw. Predicate patterns that clear the lane bit while setting the seven ignored bits check that only bit `8i` enables lane `i`.

// File: rtl/vrshr_pkg.sv
package vrshr_pkg;

    localparam int LANE_W   = 64;
    localparam int GRP_W    = LANE_W / 8;
    localparam int SHAMT_W  = $clog2(LANE_W) + 1;

    typedef enum logic [1:0] {
        RS_IDLE = 2'd0,
        RS_OK   = 2'd1,
        RS_BAD  = 2'd2
    } res_state_e;

    function automatic logic shamt_in_range(input logic [SHAMT_W-1:0] s);
        return (s >= SHAMT_W'(1)) && (s <= SHAMT_W'(LANE_W));
    endfunction

endpackage

// File: rtl/vrshr_lane.sv
module vrshr_lane
    import vrshr_pkg::*;
(
    input  logic [LANE_W-1:0]  lane_in,
    input  logic [SHAMT_W-1:0] shamt,
    input  logic               lane_en,
    output logic [LANE_W-1:0]  lane_out
);
    localparam int WIDE_W = LANE_W + 1;

    logic [WIDE_W-1:0] half_weight;
    logic [WIDE_W-1:0] biased;
    logic [LANE_W-1:0] rounded;

    always_comb begin
        half_weight = WIDE_W'(1) << (shamt - SHAMT_W'(1));
        biased      = {1'b0, lane_in} + half_weight;
        rounded     = LANE_W'(biased >> shamt);
        lane_out    = lane_en ? rounded : lane_in;
    end

endmodule

// File: rtl/vrshr_pred_map.sv
module vrshr_pred_map
    import vrshr_pkg::*;
#(
    parameter int LANES = 2
)(
    input  logic [LANES*GRP_W-1:0] pred,
    input  logic                   shamt_ok,
    output logic [LANES-1:0]       lane_en
);
    logic unused_pred_bits;
    assign unused_pred_bits = ^pred;

    for (genvar i = 0; i < LANES; i++) begin : g_lane_en
        assign lane_en[i] = pred[i*GRP_W] & shamt_ok;
    end

endmodule

// File: rtl/vrshr_ctrl.sv
module vrshr_ctrl
    import vrshr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic op_valid,
    input  logic shamt_ok,
    output logic res_valid,
    output logic res_err
);
    res_state_e state_q;
    res_state_e state_d;

    always_comb begin
        unique case ({op_valid, shamt_ok})
            2'b11:   state_d = RS_OK;
            2'b10:   state_d = RS_BAD;
            default: state_d = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            RS_OK: begin
                res_valid = 1'b1;
                res_err   = 1'b0;
            end
            RS_BAD: begin
                res_valid = 1'b1;
                res_err   = 1'b1;
            end
            default: begin
                res_valid = 1'b0;
                res_err   = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/vrshr_unit.sv
module vrshr_unit
    import vrshr_pkg::*;
#(
    parameter int VLEN = 512
)(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  op_valid,
    input  logic [VLEN-1:0]       op_vec,
    input  logic [VLEN/8-1:0]     op_pred,
    input  logic [SHAMT_W-1:0]    op_shamt,
    output logic                  res_valid,
    output logic [VLEN-1:0]       res_vec,
    output logic                  res_err
);
    localparam int LANES = VLEN / LANE_W;

    if (!(VLEN == 128 || VLEN == 256 || VLEN == 512 ||
          VLEN == 1024 || VLEN == 2048)) begin : g_bad_vlen
        $error("vrshr_unit: VLEN must be 128, 256, 512, 1024 or 2048");
    end

    logic             shamt_ok;
    logic [LANES-1:0] lane_en;
    logic [VLEN-1:0]  next_vec;

    assign shamt_ok = shamt_in_range(op_shamt);

    vrshr_pred_map #(.LANES(LANES)) u_pred (
        .pred     (op_pred),
        .shamt_ok (shamt_ok),
        .lane_en  (lane_en)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        vrshr_lane u_lane (
            .lane_in  (op_vec[i*LANE_W +: LANE_W]),
            .shamt    (op_shamt),
            .lane_en  (lane_en[i]),
            .lane_out (next_vec[i*LANE_W +: LANE_W])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        res_vec <= '0;
        else if (op_valid) res_vec <= next_vec;
    end

    vrshr_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .shamt_ok  (shamt_ok),
        .res_valid (res_valid),
        .res_err   (res_err)
    );

endmodule

// File: rtl/vrshr_unit_chk.sv
module vrshr_unit_chk
    import vrshr_pkg::*;
#(
    parameter int VLEN = 512
)(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  op_valid,
    input logic [VLEN-1:0]       op_vec,
    input logic [VLEN/8-1:0]     op_pred,
    input logic [SHAMT_W-1:0]    op_shamt,
    input logic                  res_valid,
    input logic [VLEN-1:0]       res_vec,
    input logic                  res_err
);
    logic legal_now;
    assign legal_now = (op_shamt != '0) && (op_shamt <= SHAMT_W'(LANE_W));

    // R2
    strobe_gives_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_valid);

    // R2
    quiet_gives_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !res_valid);

    // R7
    bad_shift_merges_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !legal_now) |=> (res_err && res_vec == $past(op_vec)));

    // R8
    good_shift_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && legal_now) |=> !res_err);

    // R6
    lane0_masked_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !op_pred[0]) |=> (res_vec[LANE_W-1:0] == $past(op_vec[LANE_W-1:0])));

    // R4
    full_shift_top_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_pred[0] && op_shamt == SHAMT_W'(LANE_W))
        |=> (res_vec[LANE_W-1:0] == {{(LANE_W-1){1'b0}}, $past(op_vec[LANE_W-1])}));

    // R9
    idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(res_vec) && !res_err));

    // R7
    err_only_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_err |-> res_valid);

endmodule

bind vrshr_unit vrshr_unit_chk #(.VLEN(VLEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_vec    (op_vec),
    .op_pred   (op_pred),
    .op_shamt  (op_shamt),
    .res_valid (res_valid),
    .res_vec   (res_vec),
    .res_err   (res_err)
);

// File: tb/vrshr_unit_test.sv
module vrshr_unit_test;
    localparam int VL = 128;
    localparam int NL = VL / 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            op_valid = 1'b0;
    logic [VL-1:0]   op_vec = '0;
    logic [VL/8-1:0] op_pred = '0;
    logic [6:0]      op_shamt = '0;
    logic            res_valid;
    logic [VL-1:0]   res_vec;
    logic            res_err;

    int n_checks = 0;
    int n_fails  = 0;

    logic          exp_valid = 1'b0;
    logic          exp_err   = 1'b0;
    logic [VL-1:0] exp_vec   = '0;
    string         tag_flags = "R1";
    string         tag_lane [NL];

    always #10 clk = ~clk;

    vrshr_unit #(.VLEN(VL)) uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_vec(op_vec),
        .op_pred(op_pred), .op_shamt(op_shamt), .res_valid(res_valid),
        .res_vec(res_vec), .res_err(res_err)
    );

    function automatic logic [63:0] ref_round(input logic [63:0] x, input int s);
        logic [63:0] base;
        base = (s >= 64) ? 64'd0 : (x >> s);
        return base + 64'(x[s-1]);
    endfunction

    task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic compare_outputs();
        check64(tag_flags, 64'(res_valid), 64'(exp_valid));
        check64(exp_err ? "R7" : (exp_valid ? "R8" : "R9"), 64'(res_err), 64'(exp_err));
        for (int i = 0; i < NL; i++)
            check64(tag_lane[i], res_vec[i*64 +: 64], exp_vec[i*64 +: 64]);
    endtask

    task automatic tick(input logic v, input logic [VL-1:0] x,
                        input logic [VL/8-1:0] p, input int s);
        logic legal;
        @(negedge clk);
        compare_outputs();
        op_valid = v;
        op_vec   = x;
        op_pred  = p;
        op_shamt = 7'(s);
        legal = (s >= 1) && (s <= 64);
        if (v) begin
            exp_valid = 1'b1;
            exp_err   = !legal;
            tag_flags = "R2";
            for (int i = 0; i < NL; i++) begin
                logic [63:0] xl;
                xl = x[i*64 +: 64];
                if (!legal) begin
                    exp_vec[i*64 +: 64] = xl;
                    tag_lane[i] = "R7";
                end else if (!p[i*8]) begin
                    exp_vec[i*64 +: 64] = xl;
                    tag_lane[i] = "R6";
                end else begin
                    exp_vec[i*64 +: 64] = ref_round(xl, s);
                    if (s == 64)        tag_lane[i] = "R4";
                    else if (&xl)       tag_lane[i] = "R5";
                    else                tag_lane[i] = "R3";
                end
            end
        end else begin
            exp_valid = 1'b0;
            exp_err   = 1'b0;
            tag_flags = "R2";
            for (int i = 0; i < NL; i++) tag_lane[i] = "R9";
        end
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    initial begin
        for (int i = 0; i < NL; i++) tag_lane[i] = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 checked by the first tick against the reset expectations
        tick(1'b0, '0, '0, 0);
        for (int s = 1; s <= 64; s++) begin
            tick(1'b1, {VL{1'b1}}, 16'h0101, s);          // R5 all ones
            tick(1'b1, {rnd64(), rnd64()}, 16'hFEFE, s);   // R6 ignored bits set
            tick(1'b1, {rnd64(), rnd64()}, 16'h0001, s);   // R6 lane 1 off
            for (int k = 0; k < 12; k++)
                tick(1'b1, {rnd64(), rnd64()}, 16'($urandom), s); // R3
        end
        tick(1'b1, {64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF}, 16'h0101, 64); // R4
        tick(1'b0, '0, '0, 0);   // R9
        tick(1'b0, '1, '1, 5);   // R9 idle ignores inputs
        tick(1'b1, {rnd64(), rnd64()}, 16'hFFFF, 0);      // R7
        for (int s = 65; s <= 127; s++)
            tick(1'b1, {rnd64(), rnd64()}, 16'($urandom), s); // R7
        tick(1'b1, {rnd64(), rnd64()}, 16'h0101, 1);      // R8 back to legal
        tick(1'b0, '0, '0, 0);
        tick(1'b0, '0, '0, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule